// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional control-flow instruction takes effect. It reads the four-bit condition field carried in the low nibble of an instruction word together with the processor's sixteen-bit status word, and raises a single "condition met" bit. Branch, call, return and conditional-execute logic each instantiate one copy and gate their action with that bit.

The sixteen codes form seven true/inverted pairs, plus two singles. In each pair the even code holds when its flag expression is zero and the odd code holds when it is nonzero. Code 0xE holds only on overflow and has no partner. Code 0xF always holds. The signed-compare pairs combine sign, overflow and zero rather than comparing magnitudes. The evaluator is purely combinational: the result follows the inputs in the same cycle.

The design has no state register, so there is no state machine and no transitions. Its structure is a term layer that reduces the status word to seven flag expressions, and a polarity layer that maps the code onto a term and its sense.

Top module: `cond_eval`

## Requirements
- R1: Code 0xF drives `cond_met` high for every status value.
- R2: With sign = status[3] and overflow = status[1], code 0x0 is met when sign equals overflow, and code 0x1 is met when they differ.
- R3: Code 0x2 is met when (sign XOR overflow) OR zero (status[2]) is 0, and code 0x3 is met when that expression is 1.
- R4: Code 0x4 is met when status[2] is 0, and code 0x5 is met when status[2] is 1.
- R5: Code 0x6 is met when carry (status[0]) is 0, and code 0x7 is met when carry is 1.
- R6: Code 0x8 is met when the 32-bit overflow flag (status[4]) is 0, and code 0x9 is met when it is 1.
- R7: Let E = NOT(status[5] OR status[4]) OR status[1]. Code 0xA is met when E is 0, and code 0xB is met when E is 1.
- R8: Code 0xC is met when logic-zero (status[6]) is 0, and code 0xD is met when it is 1.
- R9: Code 0xE is met exactly when status[1] is 1.
- R10: Status bits 7 to 15 have no effect on `cond_met` for any code.
- R11: For codes 0x0 to 0xD and a fixed status, the odd code of each pair gives the inverse of its even partner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_field | input | 4 | Condition code, taken from instruction bits [3:0] |
| status | input | 16 | Processor status word |
| cond_met | output | 1 | High when the selected condition holds |

## Verification
The bench targets the signed-compare pairs with sign and overflow both set. A design that compared sign alone, or dropped the zero term from G/LE, gets those cases wrong. It also sweeps code 0xE with overflow clear to expose a design that pairs 0xE with an inverse like the other codes. The mixed-flag pair 0xA/0xB is driven through all eight combinations of bits 5, 4 and 1, which catches a wrong bit position or a swapped polarity. Upper status bits are toggled with the low bits held fixed, so a decoder that reads outside the flag map shows up as a changed output.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    localparam int unsigned COND_W = 4;
    localparam int unsigned NUM_CODES = 1 << COND_W;
    localparam int unsigned NUM_PAIRS = 7;

    typedef enum logic [COND_W-1:0] {
        CC_GE   = 4'h0,
        CC_LT   = 4'h1,
        CC_GT   = 4'h2,
        CC_LE   = 4'h3,
        CC_NZ   = 4'h4,
        CC_Z    = 4'h5,
        CC_NC   = 4'h6,
        CC_C    = 4'h7,
        CC_NW   = 4'h8,
        CC_W    = 4'h9,
        CC_MX0  = 4'hA,
        CC_MX1  = 4'hB,
        CC_NLZ  = 4'hC,
        CC_LZ   = 4'hD,
        CC_OV   = 4'hE,
        CC_ALW  = 4'hF
    } cond_code_e;

endpackage

// File: rtl/cond_terms.sv
module cond_terms #(
    parameter int unsigned SR_W     = 16,
    parameter int unsigned B_CARRY  = 0,
    parameter int unsigned B_OVF    = 1,
    parameter int unsigned B_ZERO   = 2,
    parameter int unsigned B_SIGN   = 3,
    parameter int unsigned B_OVF32  = 4,
    parameter int unsigned B_TOP    = 5,
    parameter int unsigned B_LZERO  = 6,
    parameter int unsigned N_TERMS  = 7
) (
    input  logic [SR_W-1:0]    status,
    output logic [N_TERMS-1:0] terms,
    output logic               ovf_flag
);

    logic less_term;

    always_comb begin
        less_term = status[B_SIGN] ^ status[B_OVF];
        terms     = '0;
        terms[0]  = less_term;
        terms[1]  = less_term | status[B_ZERO];
        terms[2]  = status[B_ZERO];
        terms[3]  = status[B_CARRY];
        terms[4]  = status[B_OVF32];
        terms[5]  = ~(status[B_TOP] | status[B_OVF32]) | status[B_OVF];
        terms[6]  = status[B_LZERO];
        ovf_flag  = status[B_OVF];
    end

    // A set zero flag must force the greater/less-equal expression high.
    always_comb begin
        if (!$isunknown(status) && status[B_ZERO])
            assert_zero_forces_le_R3: assert (terms[1] == 1'b1)
                else $error("zero flag set but G/LE term clear");
    end

endmodule

// File: rtl/cond_select.sv
module cond_select
    import cond_eval_pkg::*;
#(
    parameter int unsigned N_TERMS = NUM_PAIRS
) (
    input  logic [COND_W-1:0]  code,
    input  logic [N_TERMS-1:0] terms,
    input  logic               ovf_flag,
    output logic               met
);

    localparam int unsigned PAIR_CODES = 2 * N_TERMS;

    logic [NUM_CODES-1:0] code_hit;

    genvar c;
    generate
        for (c = 0; c < NUM_CODES; c++) begin : g_code
            if (c < PAIR_CODES) begin : g_pair
                if (c % 2 == 0) begin : g_even
                    assign code_hit[c] = ~terms[c/2];
                end else begin : g_odd
                    assign code_hit[c] = terms[c/2];
                end
            end else if (c == int'(CC_OV)) begin : g_ovf
                assign code_hit[c] = ovf_flag;
            end else begin : g_always
                assign code_hit[c] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        met = code_hit[code];
    end

    // Within each pair the two codes never agree.
    always_comb begin
        if (!$isunknown(terms))
            for (int p = 0; p < int'(N_TERMS); p++)
                assert_pair_inverse_R11: assert (code_hit[2*p] != code_hit[2*p+1])
                    else $error("pair %0d codes agree", p);
    end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_eval_pkg::*;
#(
    parameter int unsigned SR_W    = 16,
    parameter int unsigned B_CARRY = 0,
    parameter int unsigned B_OVF   = 1,
    parameter int unsigned B_ZERO  = 2,
    parameter int unsigned B_SIGN  = 3,
    parameter int unsigned B_OVF32 = 4,
    parameter int unsigned B_TOP   = 5,
    parameter int unsigned B_LZERO = 6
) (
    input  logic [3:0]      cond_field,
    input  logic [SR_W-1:0] status,
    output logic            cond_met
);

    logic [NUM_PAIRS-1:0] terms;
    logic                 ovf_flag;

    cond_terms #(
        .SR_W    (SR_W),
        .B_CARRY (B_CARRY),
        .B_OVF   (B_OVF),
        .B_ZERO  (B_ZERO),
        .B_SIGN  (B_SIGN),
        .B_OVF32 (B_OVF32),
        .B_TOP   (B_TOP),
        .B_LZERO (B_LZERO),
        .N_TERMS (NUM_PAIRS)
    ) u_terms (
        .status   (status),
        .terms    (terms),
        .ovf_flag (ovf_flag)
    );

    cond_select #(
        .N_TERMS (NUM_PAIRS)
    ) u_select (
        .code     (cond_field),
        .terms    (terms),
        .ovf_flag (ovf_flag),
        .met      (cond_met)
    );

    always_comb begin
        if (!$isunknown({cond_field, status, cond_met})) begin
            if (cond_field == CC_ALW)
                assert_always_met_R1: assert (cond_met)
                    else $error("always code not met");
            if (cond_field == CC_LT && status[B_SIGN] == status[B_OVF])
                assert_less_clear_R2: assert (!cond_met)
                    else $error("L met with sign equal to overflow");
            if (cond_field == CC_Z)
                assert_zero_code_R4: assert (cond_met == status[B_ZERO])
                    else $error("Z code disagrees with zero flag");
            if (cond_field == CC_OV)
                assert_ovf_code_R9: assert (cond_met == status[B_OVF])
                    else $error("overflow code disagrees with flag");
        end
    end

endmodule

// File: tb/cond_eval_tb.sv
module cond_eval_tb;

    logic        clk = 1'b0;
    logic [3:0]  cond_field;
    logic [15:0] status;
    logic        cond_met;
    int          checks = 0;
    int          errors = 0;
    bit          timed_out = 1'b0;

    always #2 clk = ~clk;

    cond_eval u_dut (
        .cond_field (cond_field),
        .status     (status),
        .cond_met   (cond_met)
    );

    function automatic bit expr_of(input logic [3:0] c, input logic [15:0] s);
        case (c[3:1])
            3'd0: return s[3] ^ s[1];
            3'd1: return (s[3] ^ s[1]) | s[2];
            3'd2: return s[2];
            3'd3: return s[0];
            3'd4: return s[4];
            3'd5: return ~(s[5] | s[4]) | s[1];
            default: return s[6];
        endcase
    endfunction

    function automatic bit ref_met(input logic [3:0] c, input logic [15:0] s);
        if (c == 4'hF) return 1'b1;
        if (c == 4'hE) return s[1];
        return c[0] ? expr_of(c, s) : ~expr_of(c, s);
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'h0, 4'h1: return "R2";
            4'h2, 4'h3: return "R3";
            4'h4, 4'h5: return "R4";
            4'h6, 4'h7: return "R5";
            4'h8, 4'h9: return "R6";
            4'hA, 4'hB: return "R7";
            4'hC, 4'hD: return "R8";
            4'hE:       return "R9";
            default:    return "R1";
        endcase
    endfunction

    task automatic apply_check(input logic [3:0] c, input logic [15:0] s, input string tag);
        @(negedge clk);
        cond_field = c;
        status     = s;
        #1;
        checks++;
        if (cond_met !== ref_met(c, s)) begin
            errors++;
            $display("FAIL %s code=%h status=%h actual=%b expected=%b",
                     tag, c, s, cond_met, ref_met(c, s));
        end
    endtask

    task automatic run_all();
        logic [15:0] s;
        bit          m_even;
        // R1: always code with an empty and a full status word
        apply_check(4'hF, 16'h0000, "R1");
        apply_check(4'hF, 16'hFFFF, "R1");
        // R2, R3: sign and overflow both set, with and without zero
        apply_check(4'h0, 16'h000A, "R2");
        apply_check(4'h1, 16'h000A, "R2");
        apply_check(4'h1, 16'h0008, "R2");
        apply_check(4'h2, 16'h000A, "R3");
        apply_check(4'h3, 16'h000E, "R3");
        apply_check(4'h2, 16'h0004, "R3");
        // R9: overflow clear and set
        apply_check(4'hE, 16'hFFFD, "R9");
        apply_check(4'hE, 16'h0002, "R9");
        // R7: every combination of bits 5, 4 and 1
        for (int k = 0; k < 8; k++) begin
            s = {10'd0, k[2], k[1], 2'b00, k[0], 1'b0};
            apply_check(4'hA, s, "R7");
            apply_check(4'hB, s, "R7");
        end
        // every code against zero and all-ones status (R4, R5, R6, R8 among them)
        for (int c = 0; c < 16; c++) begin
            apply_check(c[3:0], 16'h0000, req_of(c[3:0]));
            apply_check(c[3:0], 16'h007F, req_of(c[3:0]));
        end
        // R10: upper status bits toggled with the low bits held fixed
        for (int c = 0; c < 16; c++) begin
            for (int lo = 0; lo < 128; lo += 37) begin
                apply_check(c[3:0], {9'h000, lo[6:0]}, "R10");
                apply_check(c[3:0], {9'h1FF, lo[6:0]}, "R10");
            end
        end
        // R11: each pair gives opposite answers for one status
        for (int k = 0; k < 40; k++) begin
            s = 16'($urandom());
            for (int p = 0; p < 7; p++) begin
                @(negedge clk);
                cond_field = 4'(2*p);
                status     = s;
                #1;
                m_even = cond_met;
                cond_field = 4'(2*p + 1);
                #1;
                checks++;
                if (cond_met === m_even) begin
                    errors++;
                    $display("FAIL R11 pair=%0d status=%h actual=%b expected=%b",
                             p, s, cond_met, ~m_even);
                end
            end
        end
        // constrained random sweep
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] rc;
            rc = 4'($urandom_range(15, 0));
            s  = 16'($urandom());
            apply_check(rc, s, req_of(rc));
        end
    endtask

    initial begin
        void'($urandom(32'h0C0D_E5EE));
        cond_field = 4'h0;
        status     = 16'h0000;
        repeat (2) @(posedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule